// File: doc/BRIEF.md
# Data Bus Tenure Grant Qualifier

This block sits in a bus master that shares a pipelined data bus with other masters. It decides when the master may take ownership of the data bus. It samples the external arbiter's grant, the shared wired-OR busy line and the two retry lines on every rising clock edge. From those registered samples and its own state, it forms a qualified grant. After a qualified grant it drives the busy line low and signals the local transfer engine with a one-cycle start pulse.

Each accepted address tenure leaves a pending data tenure in a small queue, which is kept oldest first. A grant always serves the head of that queue. An address retry removes the newest pending entry. When that entry is the only one and its address tenure is still open, the same retry also blocks ownership. When older pipelined entries are waiting, the retry does not stop them from being served. A data retry ends the current attempt, and the entry stays at the head so that it is served again. Every release of the busy line is followed by a forced idle cycle. This gap applies even when the rest of the system ignores the shared line.

Top module: `dbus_tenure_qual`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears the queue and negates the sampled lines. After that edge `busy_out_n`=1, `own_start`=0, `pend_cnt`=0 and `own_tag`=0.
- R2: Ownership needs a qualified grant. The following must hold together at one rising edge: `bus_dgnt_n`=0, `bus_busy_n`=1 and `bus_dretry_n`=1. At least one tenure must be pending, and the block must be neither owning nor in its release gap. Under these conditions `busy_out_n` goes to 0 after the following edge.
- R3: `own_start` is a one-cycle pulse. It appears in the first cycle in which `busy_out_n` is 0. `own_tag` always shows the tag of the oldest pending tenure, or 0 when the queue is empty.
- R4: The shared busy line low (driven by any master) blocks qualification. A line pulled high with no driver counts as free.
- R5: A sampled `bus_dretry_n`=0 blocks qualification. If it is sampled while the block owns the bus, `busy_out_n` returns to 1 after the next edge. The tenure stays at the head of the queue and is served again on a later qualified grant.
- R6: Consider a sampled `bus_aretry_n`=0 together with a sampled `addr_active`=1 while exactly one tenure is pending. The block does not take ownership and discards that entry.
- R7: Consider the same retry with two tenures pending. Only the newest entry is discarded, and a coincident grant still gives ownership for the oldest one.
- R8: `xfer_last`=1 at an edge while owning releases `busy_out_n` to 1 after that edge and removes the head entry. While not owning, `xfer_last` has no effect.
- R9: After every release, `busy_out_n` stays 1 for at least two cycles, even with the grant held and the shared line free.
- R10: The queue holds DEPTH entries (default 2) and serves them in push order. An `addr_push` while full is ignored, and count and tags stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_dgnt_n | input | 1 | Data bus grant from system arbiter, active low |
| bus_busy_n | input | 1 | Shared data-bus-busy line as seen on the bus, active low, pulled up |
| bus_dretry_n | input | 1 | Data retry, active low |
| bus_aretry_n | input | 1 | Address retry, active low |
| addr_push | input | 1 | Own address tenure accepted; queues a pending data tenure |
| addr_tag | input | TAG_W | Tag stored with the pushed tenure |
| addr_active | input | 1 | Own address tenure currently open |
| xfer_last | input | 1 | Transfer engine finished the last beat |
| busy_out_n | output | 1 | Own drive of the busy line (0 = drive low, 1 = release) |
| own_start | output | 1 | One-cycle pulse: data ownership granted |
| own_tag | output | TAG_W | Tag of the oldest pending tenure |
| pend_cnt | output | $clog2(DEPTH+1) | Number of pending data tenures |

## Verification
The assertions check every cycle that each start pulse coincides with the first low cycle of the busy drive and follows a grant sampled as qualified two edges before. They also check that every release leaves a gap, that the pulse never lasts two cycles, that the pending count stays within bounds and that ownership never exists with an empty queue. Several behaviours appear only in the bench's scenarios, which are compared with a behavioural queue model: retry-driven discards of the newest entry, the overlap case that suppresses ownership, re-service after a data retry, ignored pushes when full and the oldest-first order.

// File: rtl/dbq_pkg.sv
package dbq_pkg;
   // Registered view of the bus lines, every field active high.
   typedef struct packed {
      logic grant;
      logic busy;
      logic dretry;
      logic aretry;
      logic addr_act;
   } dbq_smp_t;
endpackage

// File: rtl/dbq_sampler.sv
module dbq_sampler
   import dbq_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     dgnt_n,
   input  logic     busy_n,
   input  logic     dretry_n,
   input  logic     aretry_n,
   input  logic     addr_act,
   output dbq_smp_t smp
);
   // Lines are captured once per edge; reset treats all as negated.
   always_ff @(posedge clk) begin
      if (rst) begin
         smp <= '0;
      end else begin
         smp.grant    <= ~dgnt_n;
         smp.busy     <= ~busy_n;
         smp.dretry   <= ~dretry_n;
         smp.aretry   <= ~aretry_n;
         smp.addr_act <= addr_act;
      end
   end
endmodule

// File: rtl/dbq_pend_queue.sv
module dbq_pend_queue #(
   parameter int DEPTH = 2,
   parameter int TAG_W = 4,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push,
   input  logic [TAG_W-1:0] push_tag,
   input  logic             deq,
   input  logic             drop,
   output logic [CNT_W-1:0] cnt,
   output logic [TAG_W-1:0] head_tag
);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("dbq_pend_queue: DEPTH must be at least 1");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("dbq_pend_queue: TAG_W must be at least 1");
      end
      if (CNT_W < $clog2(DEPTH + 1)) begin : g_bad_cnt
         $error("dbq_pend_queue: CNT_W too narrow for DEPTH");
      end
   endgenerate

   logic [TAG_W-1:0] slot_q [DEPTH];
   logic [TAG_W-1:0] slot_d [DEPTH];
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] n_v;

   // Order of operations: retire head, discard newest, then append.
   always_comb begin
      slot_d = slot_q;
      n_v    = cnt_q;
      if (deq && n_v != '0) begin
         for (int i = 0; i < DEPTH - 1; i++) begin
            slot_d[i] = slot_d[i+1];
         end
         n_v = n_v - CNT_W'(1);
      end
      if (drop && n_v != '0) begin
         n_v = n_v - CNT_W'(1);
      end
      if (push && n_v < CNT_W'(DEPTH)) begin
         slot_d[n_v[IDX_W-1:0]] = push_tag;
         n_v = n_v + CNT_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            slot_q[i] <= '0;
         end
      end else begin
         cnt_q  <= n_v;
         slot_q <= slot_d;
      end
   end

   assign cnt      = cnt_q;
   assign head_tag = (cnt_q != '0) ? slot_q[0] : '0;
endmodule

// File: rtl/dbq_tenure_ctl.sv
module dbq_tenure_ctl
   import dbq_pkg::*;
#(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  dbq_smp_t         smp,
   input  logic [CNT_W-1:0] pend_cnt,
   input  logic             xfer_last,
   output logic             busy_out_n,
   output logic             own_start,
   output logic             deq,
   output logic             drop
);
   logic act_q, gap_q, start_q;
   logic one_left, any_pend, ar_own, idle, qual, ten_end;

   always_comb begin
      one_left = (pend_cnt == CNT_W'(1));
      any_pend = (pend_cnt != '0);
      ar_own   = smp.aretry & smp.addr_act;
      idle     = ~act_q & ~gap_q;
      // Retry hits the sole entry while its address tenure is open: overlap.
      qual     = idle & any_pend & smp.grant & ~smp.busy & ~smp.dretry
                 & ~(ar_own & one_left);
      ten_end  = act_q & (xfer_last | smp.dretry);
      deq      = act_q & xfer_last & ~smp.dretry;
      drop     = ar_own & any_pend & ~(act_q & one_left);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         act_q   <= 1'b0;
         gap_q   <= 1'b0;
         start_q <= 1'b0;
      end else begin
         start_q <= qual;
         gap_q   <= ten_end;
         if (qual)         act_q <= 1'b1;
         else if (ten_end) act_q <= 1'b0;
      end
   end

   assign busy_out_n = ~act_q;
   assign own_start  = start_q;
endmodule

// File: rtl/dbus_tenure_qual.sv
module dbus_tenure_qual
   import dbq_pkg::*;
#(
   parameter int DEPTH = 2,
   parameter int TAG_W = 4,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bus_dgnt_n,
   input  logic             bus_busy_n,
   input  logic             bus_dretry_n,
   input  logic             bus_aretry_n,
   input  logic             addr_push,
   input  logic [TAG_W-1:0] addr_tag,
   input  logic             addr_active,
   input  logic             xfer_last,
   output logic             busy_out_n,
   output logic             own_start,
   output logic [TAG_W-1:0] own_tag,
   output logic [CNT_W-1:0] pend_cnt
);
   dbq_smp_t smp;
   logic     deq, drop;

   dbq_sampler u_smp (
      .clk      (clk),
      .rst      (rst),
      .dgnt_n   (bus_dgnt_n),
      .busy_n   (bus_busy_n),
      .dretry_n (bus_dretry_n),
      .aretry_n (bus_aretry_n),
      .addr_act (addr_active),
      .smp      (smp)
   );

   dbq_pend_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_q (
      .clk      (clk),
      .rst      (rst),
      .push     (addr_push),
      .push_tag (addr_tag),
      .deq      (deq),
      .drop     (drop),
      .cnt      (pend_cnt),
      .head_tag (own_tag)
   );

   dbq_tenure_ctl #(.CNT_W(CNT_W)) u_ctl (
      .clk        (clk),
      .rst        (rst),
      .smp        (smp),
      .pend_cnt   (pend_cnt),
      .xfer_last  (xfer_last),
      .busy_out_n (busy_out_n),
      .own_start  (own_start),
      .deq        (deq),
      .drop       (drop)
   );
endmodule

// File: rtl/dbq_checker.sv
module dbq_checker #(
   parameter int DEPTH = 2,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst,
   input logic             bus_dgnt_n,
   input logic             bus_busy_n,
   input logic             bus_dretry_n,
   input logic             busy_out_n,
   input logic             own_start,
   input logic [CNT_W-1:0] pend_cnt
);
   // R3
   start_busy_chk: assert property (@(posedge clk) disable iff (rst)
      own_start |-> (!busy_out_n && $past(busy_out_n)));

   // R3
   start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      own_start |=> !own_start);

   // R2
   grant_qual_chk: assert property (@(posedge clk) disable iff (rst)
      own_start |-> ($past(bus_dgnt_n, 2) == 1'b0 && $past(bus_busy_n, 2)
                     && $past(bus_dretry_n, 2)));

   // R9
   release_gap_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(busy_out_n) |=> busy_out_n);

   // R10
   cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
      pend_cnt <= CNT_W'(DEPTH));

   // R8
   own_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
      !busy_out_n |-> pend_cnt != '0);
endmodule

bind dbus_tenure_qual dbq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .bus_dgnt_n   (bus_dgnt_n),
   .bus_busy_n   (bus_busy_n),
   .bus_dretry_n (bus_dretry_n),
   .busy_out_n   (busy_out_n),
   .own_start    (own_start),
   .pend_cnt     (pend_cnt)
);

// File: tb/dbus_tenure_qual_tb.sv
module dbus_tenure_qual_tb;
   localparam int DEPTH = 2;
   localparam int TAG_W = 4;
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic dgnt_n = 1'b1, other_busy_n = 1'b1, dretry_n = 1'b1, aretry_n = 1'b1;
   logic addr_push = 1'b0, addr_active = 1'b0, xfer_last = 1'b0;
   logic [TAG_W-1:0] addr_tag = '0;
   logic             busy_out_n, own_start;
   logic [TAG_W-1:0] own_tag;
   logic [CNT_W-1:0] pend_cnt;
   logic             bus_busy_n;

   int    n_run = 0, n_fail = 0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   // Wired line: low if this master or another one drives it.
   assign bus_busy_n = busy_out_n & other_busy_n;

   dbus_tenure_qual #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_dut (
      .clk(clk), .rst(rst), .bus_dgnt_n(dgnt_n), .bus_busy_n(bus_busy_n),
      .bus_dretry_n(dretry_n), .bus_aretry_n(aretry_n), .addr_push(addr_push),
      .addr_tag(addr_tag), .addr_active(addr_active), .xfer_last(xfer_last),
      .busy_out_n(busy_out_n), .own_start(own_start), .own_tag(own_tag),
      .pend_cnt(pend_cnt)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Behavioural reference model
   int  m_q[$];
   bit  m_act, m_gap, m_start;
   bit  s_g, s_b, s_dr, s_ar, s_aa;

   always @(posedge clk) begin
      bit qual, tend, deq, drop;
      int sz;
      if (rst) begin
         m_q.delete();
         m_act = 0; m_gap = 0; m_start = 0;
         s_g = 0; s_b = 0; s_dr = 0; s_ar = 0; s_aa = 0;
      end else begin
         sz   = m_q.size();
         qual = !m_act && !m_gap && sz > 0 && s_g && !s_b && !s_dr
                && !(s_ar && s_aa && sz == 1);
         tend = m_act && (xfer_last || s_dr);
         deq  = m_act && xfer_last && !s_dr;
         drop = s_ar && s_aa && sz > 0 && !(m_act && sz == 1);
         s_b  = m_act || !other_busy_n;
         s_g  = !dgnt_n; s_dr = !dretry_n; s_ar = !aretry_n; s_aa = addr_active;
         if (deq) void'(m_q.pop_front());
         if (drop && m_q.size() > 0) void'(m_q.pop_back());
         if (addr_push && m_q.size() < DEPTH) m_q.push_back(int'(addr_tag));
         m_start = qual;
         if (qual) m_act = 1;
         else if (tend) m_act = 0;
         m_gap = tend;
      end
   end

   always @(posedge clk) begin
      int exp_tag;
      #5;
      exp_tag = (m_q.size() > 0) ? m_q[0] : 0;
      chk(busy_out_n == !m_act, cur_req, "busy_out_n", int'(busy_out_n), int'(!m_act));
      chk(own_start == m_start, cur_req, "own_start", int'(own_start), int'(m_start));
      chk(int'(pend_cnt) == m_q.size(), cur_req, "pend_cnt", int'(pend_cnt), m_q.size());
      chk(int'(own_tag) == exp_tag, cur_req, "own_tag", int'(own_tag), exp_tag);
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push(input int tag);
      addr_push = 1'b1; addr_tag = TAG_W'(tag); addr_active = 1'b1;
      cyc(1);
      addr_push = 1'b0; addr_active = 1'b0;
   endtask

   task automatic finish_run;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual 20000 cycles expected fewer");
      finish_run();
   end

   initial begin
      cyc(3);
      // R1: reset state
      chk(busy_out_n == 1'b1, "R1", "busy after reset", int'(busy_out_n), 1);
      chk(pend_cnt == '0, "R1", "count after reset", int'(pend_cnt), 0);
      rst = 1'b0;
      cyc(2);

      // R2 / R3: basic qualified grant
      cur_req = "R2";
      push(3);
      dgnt_n = 1'b0; cyc(1); dgnt_n = 1'b1;
      cyc(1);
      chk(busy_out_n == 1'b0, "R2", "busy after grant", int'(busy_out_n), 0);
      chk(own_start == 1'b1, "R3", "start pulse", int'(own_start), 1);
      chk(own_tag == 4'd3, "R3", "owned tag", int'(own_tag), 3);
      cyc(3);
      // R8: completion and idle completion
      cur_req = "R8";
      xfer_last = 1'b1; cyc(1); xfer_last = 1'b0;
      chk(busy_out_n == 1'b1, "R8", "release", int'(busy_out_n), 1);
      chk(pend_cnt == '0, "R8", "dequeued", int'(pend_cnt), 0);
      cyc(3);
      push(6);
      xfer_last = 1'b1; cyc(1); xfer_last = 1'b0;
      chk(pend_cnt == 2'd1, "R8", "idle xfer_last ignored", int'(pend_cnt), 1);
      dgnt_n = 1'b0; cyc(3); dgnt_n = 1'b1;
      xfer_last = 1'b1; cyc(1); xfer_last = 1'b0;
      cyc(3);

      // R4: another master holds the shared line
      cur_req = "R4";
      push(7);
      other_busy_n = 1'b0; dgnt_n = 1'b0;
      cyc(4);
      chk(busy_out_n == 1'b1, "R4", "blocked by shared busy", int'(busy_out_n), 1);
      other_busy_n = 1'b1;
      cyc(3);
      chk(busy_out_n == 1'b0, "R4", "granted when free", int'(busy_out_n), 0);
      dgnt_n = 1'b1;
      xfer_last = 1'b1; cyc(1); xfer_last = 1'b0;
      cyc(3);

      // R5: data retry blocks, and ends an owned attempt
      cur_req = "R5";
      push(9);
      dgnt_n = 1'b0; dretry_n = 1'b0;
      cyc(3);
      chk(busy_out_n == 1'b1, "R5", "blocked by dretry", int'(busy_out_n), 1);
      dretry_n = 1'b1;
      cyc(3);
      dgnt_n = 1'b1;
      dretry_n = 1'b0; cyc(1); dretry_n = 1'b1;
      cyc(1);
      chk(busy_out_n == 1'b1, "R5", "attempt ended", int'(busy_out_n), 1);
      chk(own_tag == 4'd9, "R5", "entry kept", int'(own_tag), 9);
      cyc(2);
      dgnt_n = 1'b0; cyc(3); dgnt_n = 1'b1;
      chk(busy_out_n == 1'b0, "R5", "served again", int'(busy_out_n), 0);
      xfer_last = 1'b1; cyc(1); xfer_last = 1'b0;
      cyc(3);

      // R6: overlap retry with a single pending tenure
      cur_req = "R6";
      addr_push = 1'b1; addr_tag = 4'd4; addr_active = 1'b1;
      dgnt_n = 1'b0; aretry_n = 1'b0;
      cyc(1); addr_push = 1'b0;
      cyc(1); addr_active = 1'b0; aretry_n = 1'b1; dgnt_n = 1'b1;
      cyc(3);
      chk(busy_out_n == 1'b1, "R6", "no ownership", int'(busy_out_n), 1);
      chk(pend_cnt == '0, "R6", "entry discarded", int'(pend_cnt), 0);

      // R7: pipelined retry hits only the newest entry
      cur_req = "R7";
      push(1);
      addr_push = 1'b1; addr_tag = 4'd2; addr_active = 1'b1;
      cyc(1); addr_push = 1'b0;
      aretry_n = 1'b0; dgnt_n = 1'b0;
      cyc(1); aretry_n = 1'b1; addr_active = 1'b0;
      cyc(2); dgnt_n = 1'b1;
      chk(busy_out_n == 1'b0, "R7", "older tenure owned", int'(busy_out_n), 0);
      chk(own_tag == 4'd1, "R7", "older tag", int'(own_tag), 1);
      chk(pend_cnt == 2'd1, "R7", "newest dropped", int'(pend_cnt), 1);
      xfer_last = 1'b1; cyc(1); xfer_last = 1'b0;
      cyc(3);

      // R10: order and full queue
      cur_req = "R10";
      push(10); push(11); push(12);
      chk(pend_cnt == 2'd2, "R10", "push when full ignored", int'(pend_cnt), 2);
      chk(own_tag == 4'd10, "R10", "head tag", int'(own_tag), 10);

      // R9: release gap with grant held
      cur_req = "R9";
      dgnt_n = 1'b0;
      cyc(3);
      xfer_last = 1'b1; cyc(1); xfer_last = 1'b0;
      chk(busy_out_n == 1'b1, "R9", "gap cycle 1", int'(busy_out_n), 1);
      cyc(1);
      chk(busy_out_n == 1'b1, "R9", "gap cycle 2", int'(busy_out_n), 1);
      cyc(1);
      chk(busy_out_n == 1'b0, "R9", "regrant after gap", int'(busy_out_n), 0);
      chk(own_tag == 4'd11, "R10", "second in order", int'(own_tag), 11);
      xfer_last = 1'b1; cyc(1); xfer_last = 1'b0;
      dgnt_n = 1'b1;
      cyc(4);
      chk(pend_cnt == '0, "R10", "drained", int'(pend_cnt), 0);

      finish_run();
   end
endmodule